// File: doc/BRIEF.md
# I2C Write-Only Register Target

This block is a synchronous I2C target that runs entirely on a local system clock. It samples the bus clock and data lines through two-flop synchronisers and finds their edges on that clock. It detects START, repeated START and STOP conditions. It drives the data line only through an active-high pull-low enable, which the pad must turn into an open-drain output.

A write transfer addresses the target with its fixed 7-bit device address. The first byte that follows is taken as a register index and loads an internal pointer. Every later byte of the same transfer is stored in a 16-entry byte register file at the pointer, and the pointer then advances by one, wrapping from the last entry back to entry 0. A repeated START begins a new address phase at once, with no STOP in between. A combinational read port exposes any register to local logic.

The finite-state machine has six states:
- `ST_IDLE`: waiting for START.
- `ST_ADDR`: receiving the address byte.
- `ST_PTR`: receiving the register-index byte.
- `ST_DATA`: receiving data bytes.
- `ST_ACK`: driving the acknowledge slot.
- `ST_IGNORE`: not addressed, waiting for the next START.

The transitions are:
- Any state goes to `ST_ADDR` on START and to `ST_IDLE` on STOP.
- A receive state goes to `ST_ACK` on the SCL falling edge after its eighth bit. The exception is a non-matching address byte in `ST_ADDR`, which goes to `ST_IGNORE`.
- `ST_ACK` goes on the falling edge that ends the ninth clock. It goes to `ST_PTR` after the address byte, and to `ST_DATA` after any other byte.

Top module: `i2c_regwr_target`

## Requirements
- R1: After reset the pull-low enable is 0 and every register reads 0x00.
- R2: An address byte is sent MSB first: the first 7 bits are the device address (default 0x2A) and the 8th bit is R/W, where 0 means write. When the address matches and R/W is 0, the target asserts the pull-low enable throughout the high phase of the ninth SCL pulse.
- R3: When the address does not match, or R/W is 1, the target does not acknowledge that byte or any later byte before the next START, and no register changes.
- R4: The first byte after an acknowledged address is acknowledged, and its low 4 bits load the register pointer.
- R5: Each byte after the register-index byte is acknowledged and stored in the register selected by the pointer.
- R6: After each stored byte the pointer increments, wrapping from 15 to 0.
- R7: The pull-low enable is 0 while SCL is high during data bits 1 to 8. It is released after the falling SCL edge that ends the ninth clock.
- R8: A repeated START without a preceding STOP restarts address reception, and the new transfer behaves as in R2 to R6.
- R9: A STOP in the middle of a byte discards the partial byte and writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| rd_idx_i | input | 4 | Register index for the read port |
| rd_data_o | output | 8 | Contents of the selected register |

## Verification
The bench builds the block with its default parameters: device address 0x2A and 16 registers. With 16 registers, a burst that starts at index 14 crosses the wrap of the pointer after only three bytes, so the wrap is reached with a short transfer. Each bus phase lasts ten system clocks, which leaves room for the synchroniser and edge latency inside every SCL half-period. This makes the acknowledge timing observable at fixed sample points.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_DATA,
        ST_ACK,
        ST_IGNORE
    } tgt_state_e;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_PTR,
        BK_DATA
    } byte_kind_e;
endpackage

// File: rtl/i2c_in_sync.sv
module i2c_in_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_line_events.sv
module i2c_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic ev_start,
    output logic ev_stop
);
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
    assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               mem_q[g] <= '0;
            else if (wr_en && wr_idx == AW'(g))       mem_q[g] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/i2c_regwr_target.sv
module i2c_regwr_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h2A,
    parameter int         REG_COUNT = 16,
    localparam int        PW        = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [PW-1:0]     rd_idx_i,
    output logic [BYTE_W-1:0] rd_data_o
);
    localparam int CW = $clog2(BYTE_W + 1);

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, ev_start, ev_stop;

    tgt_state_e        state_q, state_d;
    byte_kind_e        kind_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [CW-1:0]     cnt_q;
    logic [PW-1:0]     ptr_q;
    logic              pull_q;
    logic              byte_full, addr_ok, in_rx, wr_en;

    i2c_in_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  ({scl_s, sda_s})
    );

    i2c_line_events u_ev (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    assign byte_full = (cnt_q == CW'(BYTE_W));
    assign addr_ok   = (shreg_q[7:1] == DEV_ADDR) && !shreg_q[0];
    assign in_rx     = (state_q == ST_ADDR) || (state_q == ST_PTR) || (state_q == ST_DATA);
    assign wr_en     = (state_q == ST_ACK) && scl_fall && (kind_q == BK_DATA);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (ev_stop) begin
            state_d = ST_IDLE;
        end else if (ev_start) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_ADDR: begin
                    if (scl_fall && byte_full) state_d = addr_ok ? ST_ACK : ST_IGNORE;
                end
                ST_PTR, ST_DATA: begin
                    if (scl_fall && byte_full) state_d = ST_ACK;
                end
                ST_ACK: begin
                    if (scl_fall) state_d = (kind_q == BK_ADDR) ? ST_PTR : ST_DATA;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pull_q  <= 1'b0;
            cnt_q   <= '0;
            shreg_q <= '0;
            kind_q  <= BK_ADDR;
            ptr_q   <= '0;
        end else begin
            pull_q <= (state_d == ST_ACK);
            if (ev_start || ev_stop) begin
                cnt_q <= '0;
            end else if (in_rx) begin
                if (scl_rise && !byte_full) begin
                    shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
                    cnt_q   <= cnt_q + 1'b1;
                end else if (scl_fall && byte_full) begin
                    cnt_q <= '0;
                end
            end
            if (in_rx && state_d == ST_ACK) begin
                unique case (state_q)
                    ST_ADDR: kind_q <= BK_ADDR;
                    ST_PTR:  kind_q <= BK_PTR;
                    default: kind_q <= BK_DATA;
                endcase
            end
            if (state_q == ST_ACK && scl_fall && !ev_start && !ev_stop) begin
                if (kind_q == BK_PTR) begin
                    ptr_q <= shreg_q[PW-1:0];
                end else if (kind_q == BK_DATA) begin
                    ptr_q <= (ptr_q == PW'(REG_COUNT - 1)) ? '0 : ptr_q + 1'b1;
                end
            end
        end
    end

    assign sda_pull_o = pull_q;

    i2c_reg_bank #(.DEPTH(REG_COUNT), .DATA_W(BYTE_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (ptr_q),
        .wr_data (shreg_q),
        .rd_idx  (rd_idx_i),
        .rd_data (rd_data_o)
    );
endmodule

// File: rtl/i2c_regwr_checker.sv
module i2c_regwr_checker
    import i2c_tgt_pkg::*;
#(
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          scl_fall,
    input logic          ev_start,
    input logic          ev_stop,
    input logic          pull,
    input logic          wr_en,
    input logic [PW-1:0] ptr,
    input tgt_state_e    state
);
    // R1: idle target never pulls the line
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !pull);

    // R2: acknowledge held across the SCL high phase
    a_r2_ack_held_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pull && scl_s && !ev_start && !ev_stop) |=> pull);

    // R3: an ignored transfer never drives the line
    a_r3_ignore_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !pull);

    // R6: pointer advances by one after each stored byte
    a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ptr == PW'($past(ptr) + 1'b1));

    // R7: release on the falling edge closing the ninth clock
    a_r7_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && scl_fall) |=> !pull);

    // R7: acknowledge only starts while SCL is low
    a_r7_pull_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull) |-> !scl_s);

    // R8: START restarts address reception
    a_r8_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> (state == ST_ADDR) && !pull);
endmodule

bind i2c_regwr_target i2c_regwr_checker #(.PW(PW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .scl_fall (scl_fall),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .pull     (pull_q),
    .wr_en    (wr_en),
    .ptr      (ptr_q),
    .state    (state_q)
);

// File: tb/i2c_regwr_target_test.sv
module i2c_regwr_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam logic [6:0] DEV = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       pull;
    logic [3:0] rd_idx = '0;
    logic [7:0] rd_data;
    logic       sda_bus;

    int n_checks = 0;
    int n_fail   = 0;
    bit in_data_high = 1'b0;
    bit done = 1'b0;

    // reference model
    logic [7:0] m_regs [16];
    int         m_ptr = 0;

    assign sda_bus = sda_m & ~pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regwr_target uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_pull_o (pull),
        .rd_idx_i   (rd_idx),
        .rd_data_o  (rd_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R7: every clock during data-bit high phases the line must stay released
    always @(negedge clk) begin
        if (in_data_high && !done) check("R7 data-phase pull", {7'b0, pull}, 8'h00);
    end

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b1; wait_q(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wait_q(Q);
        scl_m = 1'b1; in_data_high = 1'b1; wait_q(2*Q);
        in_data_high = 1'b0; scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, input logic exp_ack, input string req);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        check(req, {7'b0, pull}, {7'b0, exp_ack});
        wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
        check("R7 release after ninth clock", {7'b0, pull}, 8'h00);
    endtask

    task automatic xfer(input logic [6:0] a, input logic rw, input logic [7:0] bytes[$], input bit stop);
        logic ok;
        do_start();
        ok = (a == DEV) && !rw;
        put_byte({a, rw}, ok, ok ? "R2 address ack" : "R3 address nack");
        foreach (bytes[i]) begin
            if (i == 0) begin
                put_byte(bytes[i], ok, ok ? "R4 index ack" : "R3 no ack after nack");
                if (ok) m_ptr = bytes[i][3:0];
            end else begin
                put_byte(bytes[i], ok, ok ? "R5 data ack" : "R3 no ack after nack");
                if (ok) begin
                    m_regs[m_ptr] = bytes[i];
                    m_ptr = (m_ptr + 1) % 16;
                end
            end
        end
        if (stop) do_stop();
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < 16; i++) begin
            rd_idx = 4'(i);
            #1;
            check(req, rd_data, m_regs[i]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m_regs[i] = 8'h00;
        wait_q(5);
        rst_n = 1'b1;
        wait_q(5);
        check("R1 pull after reset", {7'b0, pull}, 8'h00);
        check_regs("R1 regs after reset");

        // R4 R5: single write
        xfer(DEV, 1'b0, '{8'h03, 8'hA5}, 1'b1);
        check_regs("R5 single write");

        // R6: burst crossing the wrap
        xfer(DEV, 1'b0, '{8'h0E, 8'h11, 8'h22, 8'h33, 8'h44}, 1'b1);
        check_regs("R6 burst wrap");

        // R3: wrong address, then read bit
        xfer(7'h2B, 1'b0, '{8'h00, 8'hFF, 8'hEE}, 1'b1);
        check_regs("R3 wrong address no write");
        xfer(DEV, 1'b1, '{8'h05, 8'h77}, 1'b1);
        check_regs("R3 read bit no write");

        // R4: upper bits of the index ignored
        xfer(DEV, 1'b0, '{8'hF7, 8'h5C}, 1'b1);
        check_regs("R4 index low bits");

        // R8: repeated START with no STOP
        xfer(DEV, 1'b0, '{8'h08, 8'h81}, 1'b0);
        xfer(DEV, 1'b0, '{8'h0A, 8'h9A, 8'h9B}, 1'b0);
        xfer(7'h10, 1'b0, '{8'h0C, 8'hCC}, 1'b0);
        xfer(DEV, 1'b0, '{8'h0D, 8'hDD}, 1'b1);
        check_regs("R8 repeated start");

        // R9: STOP inside a data byte
        do_start();
        put_byte({DEV, 1'b0}, 1'b1, "R2 address ack");
        put_byte(8'h09, 1'b1, "R4 index ack");
        m_ptr = 9;
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        do_stop();
        check("R9 pull after abort", {7'b0, pull}, 8'h00);
        check_regs("R9 partial byte discarded");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule